// File: doc/BRIEF.md
# Lookahead Thread Issue Gate

This block decides, every cycle, which hardware threads of a heavily multithreaded pipeline may send another instruction into execution. Each issued instruction carries a 3-bit lookahead value, from 0 to 7. The value says how many of the thread's later instructions do not depend on it. A thread therefore needs no register scoreboard. It may keep several instructions in flight as long as each new one falls inside the window that the earlier ones granted. Fewer threads are then needed to keep the pipeline full.

The thread scheduler presents at most one issue event per cycle, made of a thread number and a lookahead value. The execution back end presents at most one completion event per cycle, made of a thread number. For each thread the block holds two counters. The first counts the instructions still in flight. The second holds the remaining independence allowance. The eligibility vector is decoded from these registered counters. An issue or completion therefore shows in the vector one clock edge after it is presented. A sticky error flag records any issue that would push a thread past its in-flight capacity.

Top module: `lkg_issue_gate`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every bit of `eligible` is 1 and `ovf_err` is 0.
- R2: An issue with lookahead 0, with no completion of the same thread in that cycle, clears that thread's `eligible` bit from the next cycle on. The bit stays clear until the thread's completions bring its in-flight count back to 0.
- R3: An issue with lookahead L to a thread with nothing in flight allows exactly L further issues before the thread becomes ineligible, provided each of those issues carries a lookahead of at least the remaining allowance.
- R4: An issue to a thread with instructions already in flight sets the remaining allowance to the smaller of two values. One is the old allowance minus one, floored at 0. The other is the new lookahead. The thread is eligible while the allowance is above 0 or its in-flight count is 0.
- R5: A completion lowers its thread's in-flight count by one. A thread blocked by a zero allowance becomes eligible only in the cycle after its count reaches 0.
- R6: An issue and a completion to the same thread in one cycle leave the in-flight count unchanged. If that completion retires the thread's only instruction, the allowance is loaded from the new lookahead, so a lookahead of 0 then blocks the thread and a lookahead above 0 keeps it eligible.
- R7: An event for one thread never changes the `eligible` bit of any other thread.
- R8: An issue to a thread that already holds MAX_INFLIGHT (default 8) instructions, with no completion of that thread in the same cycle, sets `ovf_err` from the next cycle on. The flag stays 1 until reset, and the in-flight count holds at MAX_INFLIGHT.
- R9: A completion for a thread with nothing in flight has no effect. After it, a lookahead-0 issue to that thread is undone by a single completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_tid | input | 3 | Thread number of the issued instruction |
| iss_la | input | 3 | Lookahead value of the issued instruction (0 to 7) |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_tid | input | 3 | Thread number of the completing instruction |
| eligible | output | 8 | Bit t is 1 when thread t may issue this cycle |
| ovf_err | output | 1 | Sticky flag: an issue exceeded a thread's in-flight capacity |

## Verification
The assertions take thread numbers to be in range, which holds for a power-of-two thread count. They also take a completion to name a thread that really has an instruction in flight, or else to be harmless. They do not assume that the scheduler issues only to eligible threads, so every property must hold even under issues that break the window. The stimulus keeps issues inside the eligibility vector everywhere except two places: the same-cycle issue-and-retire case, and the deliberate capacity overrun. Both are deliberate, so those paths are exercised against the properties as well.

// File: rtl/lkg_pkg.sv
// Package: shared types for the lookahead issue gate.
// Holds the per-thread allowance update selector used by each thread slot.
package lkg_pkg;

    // Selects how a thread's remaining allowance is updated this cycle.
    typedef enum logic [1:0] {
        ALW_HOLD   = 2'd0,   // no change
        ALW_LOAD   = 2'd1,   // fresh window from the issued lookahead
        ALW_SHRINK = 2'd2,   // min(old - 1, new lookahead)
        ALW_CLEAR  = 2'd3    // thread drained; restriction dropped
    } alw_op_e;

endpackage

// File: rtl/lkg_onehot_dec.sv
// Module: lkg_onehot_dec
// Turns a qualified thread number into a one-hot hit vector.
// Assumes idx is below N when valid is high.
module lkg_onehot_dec #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         valid,
    input  logic [W-1:0] idx,
    output logic [N-1:0] hit
);

    // One comparator per thread.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid && (idx == W'(g));
    end

endmodule

// File: rtl/lkg_thread_slot.sv
// Module: lkg_thread_slot
// Tracks one thread: in-flight count and remaining lookahead allowance.
// Assumes: at most one issue and one completion for this thread per cycle.
// A completion is applied before the issue in the same cycle.
// Completions with nothing in flight are dropped.
module lkg_thread_slot
    import lkg_pkg::*;
#(
    parameter int LA_W       = 3,
    parameter int MAX_INFL   = 8,
    localparam int CNT_W     = $clog2(MAX_INFL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_hit,
    input  logic [LA_W-1:0] iss_la,
    input  logic            cmp_hit,
    output logic            eligible,
    output logic            ovf_pulse
);

    logic [CNT_W-1:0] infl_q;
    logic [CNT_W-1:0] infl_ret;
    logic [CNT_W-1:0] infl_d;
    logic [LA_W-1:0]  alw_q;
    logic [LA_W-1:0]  alw_dec;
    logic [LA_W-1:0]  alw_d;
    alw_op_e          alw_op;

    // In-flight count: retire first, then add the issue unless at capacity.
    always_comb begin
        infl_ret  = (cmp_hit && (infl_q != '0)) ? infl_q - CNT_W'(1) : infl_q;
        ovf_pulse = iss_hit && (infl_ret == CNT_W'(MAX_INFL));
        infl_d    = (iss_hit && !ovf_pulse) ? infl_ret + CNT_W'(1) : infl_ret;
    end

    // Choose the allowance update from the post-retire count.
    always_comb begin
        if (iss_hit) begin
            alw_op = (infl_ret == '0) ? ALW_LOAD : ALW_SHRINK;
        end else if (infl_d == '0) begin
            alw_op = ALW_CLEAR;
        end else begin
            alw_op = ALW_HOLD;
        end
    end

    // Compute the next allowance value.
    always_comb begin
        alw_dec = (alw_q == '0) ? '0 : alw_q - LA_W'(1);
        unique case (alw_op)
            ALW_LOAD:   alw_d = iss_la;
            ALW_SHRINK: alw_d = (iss_la < alw_dec) ? iss_la : alw_dec;
            ALW_CLEAR:  alw_d = '0;
            default:    alw_d = alw_q;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            infl_q <= '0;
            alw_q  <= '0;
        end else begin
            infl_q <= infl_d;
            alw_q  <= alw_d;
        end
    end

    // Thread may issue when drained or when window remains.
    assign eligible = (infl_q == '0) || (alw_q != '0);

endmodule

// File: rtl/lkg_issue_gate.sv
// Module: lkg_issue_gate (top)
// Per-thread issue eligibility from instruction lookahead counts.
// Assumes: one issue and one completion event per cycle at most,
// and thread numbers below NUM_THREADS.
module lkg_issue_gate #(
    parameter int NUM_THREADS  = 8,
    parameter int MAX_INFLIGHT = 8,
    parameter int LA_W         = 3,
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid,
    input  logic [TID_W-1:0]       iss_tid,
    input  logic [LA_W-1:0]        iss_la,
    input  logic                   cmp_valid,
    input  logic [TID_W-1:0]       cmp_tid,
    output logic [NUM_THREADS-1:0] eligible,
    output logic                   ovf_err
);

    logic [NUM_THREADS-1:0] iss_hit;
    logic [NUM_THREADS-1:0] cmp_hit;
    logic [NUM_THREADS-1:0] ovf_vec;
    logic                   err_q;

    // Decode the issue event.
    lkg_onehot_dec #(.N(NUM_THREADS)) u_iss_dec (
        .valid (iss_valid),
        .idx   (iss_tid),
        .hit   (iss_hit)
    );

    // Decode the completion event.
    lkg_onehot_dec #(.N(NUM_THREADS)) u_cmp_dec (
        .valid (cmp_valid),
        .idx   (cmp_tid),
        .hit   (cmp_hit)
    );

    // One tracking slot per thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        lkg_thread_slot #(
            .LA_W     (LA_W),
            .MAX_INFL (MAX_INFLIGHT)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_hit   (iss_hit[t]),
            .iss_la    (iss_la),
            .cmp_hit   (cmp_hit[t]),
            .eligible  (eligible[t]),
            .ovf_pulse (ovf_vec[t])
        );
    end

    // Sticky capacity-overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_q | (|ovf_vec);
        end
    end

    assign ovf_err = err_q;

endmodule

// File: rtl/lkg_issue_gate_chk.sv
// Module: lkg_issue_gate_chk
// Port-level properties of the issue gate, bound into every instance.
module lkg_issue_gate_chk #(
    parameter int NUM_THREADS = 8,
    parameter int LA_W        = 3,
    parameter int TID_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   iss_valid,
    input logic [TID_W-1:0]       iss_tid,
    input logic [LA_W-1:0]        iss_la,
    input logic                   cmp_valid,
    input logic [TID_W-1:0]       cmp_tid,
    input logic [NUM_THREADS-1:0] eligible,
    input logic                   ovf_err
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (eligible == '1) && !ovf_err); // R1

    AST_ZERO_LA_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_la == '0 && !(cmp_valid && cmp_tid == iss_tid))
        |=> !eligible[$past(iss_tid)]); // R2

    AST_RETIRE_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !iss_valid && eligible[cmp_tid])
        |=> eligible[$past(cmp_tid)]); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err); // R8

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_iso
        AST_OTHER_THREAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!(iss_valid && iss_tid == TID_W'(t)) && !(cmp_valid && cmp_tid == TID_W'(t)))
            |=> (eligible[t] == $past(eligible[t]))); // R7
    end

endmodule

bind lkg_issue_gate lkg_issue_gate_chk #(
    .NUM_THREADS (NUM_THREADS),
    .LA_W        (LA_W),
    .TID_W       (TID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_tid   (iss_tid),
    .iss_la    (iss_la),
    .cmp_valid (cmp_valid),
    .cmp_tid   (cmp_tid),
    .eligible  (eligible),
    .ovf_err   (ovf_err)
);

// File: tb/lkg_issue_gate_test.sv
// Bench: driver pushes expected results into a scoreboard; a monitor compares.
module lkg_issue_gate_test;

    localparam int NT  = 8;
    localparam int MAX = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [2:0]    iss_tid = '0;
    logic [2:0]    iss_la = '0;
    logic          cmp_valid = 1'b0;
    logic [2:0]    cmp_tid = '0;
    logic [NT-1:0] eligible;
    logic          ovf_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string         q_tag[$];
    logic [NT-1:0] q_elig[$];
    logic          q_err[$];

    // Requirement-level model state.
    int  m_cnt[NT];
    int  m_alw[NT];
    bit  m_err;

    always #4 clk = ~clk;   // 125 MHz

    lkg_issue_gate uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_tid   (iss_tid),
        .iss_la    (iss_la),
        .cmp_valid (cmp_valid),
        .cmp_tid   (cmp_tid),
        .eligible  (eligible),
        .ovf_err   (ovf_err)
    );

    function automatic logic [NT-1:0] model_elig();
        logic [NT-1:0] v;
        for (int t = 0; t < NT; t++) v[t] = (m_cnt[t] == 0) || (m_alw[t] > 0);
        return v;
    endfunction

    // Apply one cycle of events, advance the model, queue the expectation.
    task automatic step(input string tag, input bit iv, input int it, input int il,
                        input bit cv, input int ct);
        int n;
        @(negedge clk);
        iss_valid = iv; iss_tid = 3'(it); iss_la = 3'(il);
        cmp_valid = cv; cmp_tid = 3'(ct);
        if (cv && m_cnt[ct] > 0) m_cnt[ct]--;
        if (iv) begin
            n = m_cnt[it];
            if (n == 0) m_alw[it] = il;
            else m_alw[it] = ((m_alw[it] > 0 ? m_alw[it] - 1 : 0) < il)
                             ? (m_alw[it] > 0 ? m_alw[it] - 1 : 0) : il;
            if (n == MAX) m_err = 1'b1;
            else m_cnt[it] = n + 1;
        end
        @(posedge clk);
        #2;
        q_tag.push_back(tag);
        q_elig.push_back(model_elig());
        q_err.push_back(m_err);
    endtask

    // Monitor: pop expectations and compare with the ports.
    initial begin
        forever begin
            wait (q_tag.size() != 0);
            begin
                string tg;
                logic [NT-1:0] ee;
                logic er;
                tg = q_tag.pop_front();
                ee = q_elig.pop_front();
                er = q_err.pop_front();
                checks++;
                if (eligible !== ee || ovf_err !== er) begin
                    errors++;
                    $display("FAIL %s: eligible=%b ovf_err=%b expected eligible=%b ovf_err=%b",
                             tg, eligible, ovf_err, ee, er);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin m_cnt[t] = 0; m_alw[t] = 0; end
        m_err = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1: during reset
        q_tag.push_back("R1 in reset"); q_elig.push_back('1); q_err.push_back(1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        q_tag.push_back("R1 after release"); q_elig.push_back('1); q_err.push_back(1'b0);

        // R2: lookahead 0 blocks thread 0
        step("R2 la0 blocks", 1, 0, 0, 0, 0);
        step("R2 stays blocked", 0, 0, 0, 0, 0);
        step("R5 drained", 0, 0, 0, 1, 0);

        // R3: window of 2 on thread 1
        step("R3 first", 1, 1, 2, 0, 0);
        step("R3 second", 1, 1, 7, 0, 0);
        step("R3 third blocks", 1, 1, 7, 0, 0);

        // R4: shrink rule on thread 2
        step("R4 load 5", 1, 2, 5, 0, 0);
        step("R4 min to 1", 1, 2, 1, 0, 0);
        step("R4 min to 0", 1, 2, 7, 0, 0);

        // R5: partial retire keeps block, full retire frees
        step("R5 retire 1", 0, 0, 0, 1, 2);
        step("R5 retire 2", 0, 0, 0, 1, 2);
        step("R5 retire 3", 0, 0, 0, 1, 2);

        // R6: same-cycle issue and retire on thread 3
        step("R6 setup la0", 1, 3, 0, 0, 0);
        step("R6 swap la3", 1, 3, 3, 1, 3);
        step("R6 swap la0", 1, 3, 0, 1, 3);
        step("R6 drain", 0, 0, 0, 1, 3);

        // R7: events on different threads in one cycle
        step("R7 cross", 1, 4, 0, 1, 1);
        step("R7 cross 2", 1, 7, 4, 1, 4);

        // R9: stray completion ignored
        step("R9 stray", 0, 0, 0, 1, 5);
        step("R9 la0", 1, 5, 0, 0, 0);
        step("R9 one retire frees", 0, 0, 0, 1, 5);

        // R8: fill thread 6 to capacity, then overrun
        for (int k = 0; k < MAX; k++) step("R8 fill", 1, 6, 7, 0, 0);
        step("R8 overrun", 1, 6, 7, 0, 0);
        for (int k = 0; k < MAX; k++) step("R8 drain sticky", 0, 0, 0, 1, 6);

        step("R7 idle", 0, 0, 0, 0, 0);
        wait (q_tag.size() == 0);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule